// File: doc/BRIEF.md
# ECAM configuration address decoder

This block sits between a memory-mapped configuration window and the configuration-request path of a PCIe root port. Each request strobe carries a window offset. The block splits the offset into bus, device, function and register fields. It then decides whether the access may travel to the link or must be completed locally. The admission rules look at the root bus number, the primary bus number of the bus being addressed, the link state, and a highest-bus limit. That limit comes from a 3-bit field of the bridge-info register.

An admitted access leaves as a one-cycle forward pulse that carries the decoded fields and the write data. The block then stays busy until the link returns a completion or a fixed wait window runs out. When the window runs out, the block raises a timeout event and returns all ones. A refused access never reaches the link. A refused read completes locally with all ones, and a refused write completes with zero data and no side effect. The block also reports the highest supported bus number for use by enumeration logic.

Top module: `cfg_win_decoder`

## Requirements
- R1: The offset splits as bus = bits [27:20], device = bits [19:15], function = bits [14:12] and register = bits [11:0]. An admitted access forwards these fields, the write flag and the write data unchanged.
- R2: A strobe taken while not busy produces, in the next cycle, exactly one of a forward pulse or a local response.
- R3: While link_up_i is low, an access to any bus other than root_bus_i is refused. An access to the root bus stays admissible.
- R4: On the root bus, any device/function pair other than device 0, function 0 is refused.
- R5: On a bus whose primary bus equals root_bus_i, any device/function pair other than 0/0 is refused.
- R6: The highest supported bus number is bridge_info_i[18:16], zero-extended on bus_max_o. An access whose bus is above it is refused, and an access to exactly that bus is admissible.
- R7: A refused read returns 0xFFFFFFFF on rsp_data_o. A refused write returns 0x00000000. Neither raises fwd_valid_o.
- R8: From the forward pulse until its completion, busy_o is high and request strobes are ignored. A link completion seen while busy is returned on rsp_data_o in the next cycle and clears busy_o.
- R9: If no completion arrives within TIMEOUT_CYC cycles after the forward pulse, the block gives timeout_evt_o and rsp_valid_o for one cycle with 0xFFFFFFFF and clears busy_o. A completion in the last cycle of the window wins over the timeout.
- R10: A link completion that arrives while the block is not busy is ignored.
- R11: After reset, busy_o, fwd_valid_o, rsp_valid_o and timeout_evt_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 28 | Offset into the configuration window |
| req_wdata_i | input | 32 | Write data |
| root_bus_i | input | 8 | Root bus number |
| prim_bus_i | input | 8 | Primary bus number of the addressed bus |
| link_up_i | input | 1 | Link is up |
| bridge_info_i | input | 32 | Bridge-info register; bits 18:16 hold the highest bus |
| cpl_valid_i | input | 1 | Completion from the link |
| cpl_data_i | input | 32 | Completion data |
| busy_o | output | 1 | A forwarded access is awaiting completion |
| fwd_valid_o | output | 1 | Forward pulse to the link side |
| fwd_write_o | output | 1 | Forwarded write flag |
| fwd_bus_o | output | 8 | Forwarded bus number |
| fwd_dev_o | output | 5 | Forwarded device number |
| fwd_fn_o | output | 3 | Forwarded function number |
| fwd_reg_o | output | 12 | Forwarded register offset |
| fwd_wdata_o | output | 32 | Forwarded write data |
| rsp_valid_o | output | 1 | Response to the requester |
| rsp_data_o | output | 32 | Response data |
| timeout_evt_o | output | 1 | Configuration access timed out |
| bus_max_o | output | 8 | Highest supported bus number |

## Verification
Two events can land in the same cycle: a link completion, and expiry of the wait window. The bench provokes this by holding back the completion until the last admissible cycle of the window. It then expects the link data on rsp_data_o with no timeout event and busy_o cleared. A run with the completion withheld for one more cycle must instead show the timeout event and all ones. Random accesses mix bus numbers near the limit, device/function zero and non-zero, link state and completion delays across the whole window. Each response is judged against a bench model of the admission rules.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned FN_W   = 3;
  localparam int unsigned REG_W  = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = BUS_W + DEV_W + FN_W + REG_W;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
  } cfg_addr_t;
endpackage

// File: rtl/cfg_addr_split.sv
module cfg_addr_split
  import cfg_dec_pkg::*;
(
  input  logic [OFS_W-1:0] ofs_i,
  output cfg_addr_t        addr_o
);
  // field order of cfg_addr_t matches the offset bit layout
  assign addr_o = ofs_i;
endmodule

// File: rtl/cfg_admit.sv
module cfg_admit
  import cfg_dec_pkg::*;
(
  input  cfg_addr_t        addr_i,
  input  logic [BUS_W-1:0] root_bus_i,
  input  logic [BUS_W-1:0] prim_bus_i,
  input  logic             link_up_i,
  input  logic [BUS_W-1:0] bus_max_i,
  output logic             ok_o
);
  logic devfn_nz, over_lim, link_block, root_block, attach_block;

  always_comb begin
    devfn_nz     = (addr_i.dev != '0) || (addr_i.fn != '0);
    over_lim     = addr_i.bus > bus_max_i;
    link_block   = (addr_i.bus != root_bus_i) && !link_up_i;
    root_block   = (addr_i.bus == root_bus_i) && devfn_nz;
    attach_block = (prim_bus_i == root_bus_i) && devfn_nz;
    ok_o         = !(over_lim || link_block || root_block || attach_block);
  end
endmodule

// File: rtl/cfg_cpl_tracker.sv
module cfg_cpl_tracker #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic cpl_valid_i,
  output logic busy_o,
  output logic take_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign take_o   = busy_q && cpl_valid_i;
  // completion in the final cycle wins over expiry
  assign expire_o = busy_q && !cpl_valid_i && (cnt_q == CNT_LAST);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (take_o || expire_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_win_decoder.sv
module cfg_win_decoder
  import cfg_dec_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16,
  parameter int unsigned INFO_W      = 32,
  parameter int unsigned LIM_LSB     = 16,
  parameter int unsigned LIM_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [OFS_W-1:0]  req_offset_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic [BUS_W-1:0]  prim_bus_i,
  input  logic              link_up_i,
  input  logic [INFO_W-1:0] bridge_info_i,
  input  logic              cpl_valid_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  output logic              busy_o,
  output logic              fwd_valid_o,
  output logic              fwd_write_o,
  output logic [BUS_W-1:0]  fwd_bus_o,
  output logic [DEV_W-1:0]  fwd_dev_o,
  output logic [FN_W-1:0]   fwd_fn_o,
  output logic [REG_W-1:0]  fwd_reg_o,
  output logic [DATA_W-1:0] fwd_wdata_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              timeout_evt_o,
  output logic [BUS_W-1:0]  bus_max_o
);
  cfg_addr_t        addr;
  logic [LIM_W-1:0] lim_field;
  logic [BUS_W-1:0] bus_max;
  logic             ok, accept, launch, take, expire, refuse;
  logic             unused_info;

  assign lim_field   = bridge_info_i[LIM_LSB +: LIM_W];
  assign unused_info = ^bridge_info_i;

  generate
    if (LIM_W < BUS_W) begin : g_lim_ext
      assign bus_max = {{(BUS_W-LIM_W){1'b0}}, lim_field};
    end else begin : g_lim_trunc
      assign bus_max = lim_field[BUS_W-1:0];
    end
  endgenerate
  assign bus_max_o = bus_max;

  cfg_addr_split u_split (
    .ofs_i  (req_offset_i),
    .addr_o (addr)
  );

  cfg_admit u_admit (
    .addr_i     (addr),
    .root_bus_i (root_bus_i),
    .prim_bus_i (prim_bus_i),
    .link_up_i  (link_up_i),
    .bus_max_i  (bus_max),
    .ok_o       (ok)
  );

  assign accept = req_valid_i && !busy_o;
  assign launch = accept && ok;
  assign refuse = accept && !ok;

  cfg_cpl_tracker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .cpl_valid_i (cpl_valid_i),
    .busy_o      (busy_o),
    .take_o      (take),
    .expire_o    (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_write_o <= 1'b0;
      fwd_bus_o   <= '0;
      fwd_dev_o   <= '0;
      fwd_fn_o    <= '0;
      fwd_reg_o   <= '0;
      fwd_wdata_o <= '0;
    end else begin
      fwd_valid_o <= launch;
      if (launch) begin
        fwd_write_o <= req_write_i;
        fwd_bus_o   <= addr.bus;
        fwd_dev_o   <= addr.dev;
        fwd_fn_o    <= addr.fn;
        fwd_reg_o   <= addr.regn;
        fwd_wdata_o <= req_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_data_o    <= '0;
      timeout_evt_o <= 1'b0;
    end else begin
      rsp_valid_o   <= refuse || take || expire;
      timeout_evt_o <= expire;
      if (take)        rsp_data_o <= cpl_data_i;
      else if (expire) rsp_data_o <= '1;
      else if (refuse) rsp_data_o <= req_write_i ? '0 : '1;
      else             rsp_data_o <= '0;
    end
  end
endmodule

// File: rtl/cfg_win_decoder_chk.sv
module cfg_win_decoder_chk
  import cfg_dec_pkg::*;
#(
  parameter int unsigned INFO_W  = 32,
  parameter int unsigned LIM_LSB = 16,
  parameter int unsigned LIM_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [OFS_W-1:0]  req_offset_i,
  input logic [BUS_W-1:0]  root_bus_i,
  input logic [BUS_W-1:0]  prim_bus_i,
  input logic              link_up_i,
  input logic [INFO_W-1:0] bridge_info_i,
  input logic              busy_o,
  input logic              fwd_valid_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              timeout_evt_o
);
  logic [BUS_W-1:0] c_bus;
  logic             c_nz, c_take, unused_chk;
  int unsigned      c_lim;

  assign c_bus      = req_offset_i[OFS_W-1 -: BUS_W];
  assign c_nz       = req_offset_i[REG_W +: (DEV_W+FN_W)] != '0;
  assign c_lim      = int'(bridge_info_i[LIM_LSB +: LIM_W]);
  assign c_take     = req_valid_i && !busy_o;
  assign unused_chk = ^{bridge_info_i, req_offset_i};

  AST_DECIDE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_take |=> (fwd_valid_o ^ rsp_valid_o)); // R2
  AST_LINK_DOWN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_take && c_bus != root_bus_i && !link_up_i) |=> (!fwd_valid_o && rsp_valid_o)); // R3
  AST_ROOT_DEV0_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_take && c_bus == root_bus_i && c_nz) |=> !fwd_valid_o); // R4
  AST_ATTACHED_DEV0_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_take && prim_bus_i == root_bus_i && c_nz) |=> !fwd_valid_o); // R5
  AST_BUS_OVER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_take && int'(c_bus) > c_lim) |=> !fwd_valid_o); // R6
  AST_REFUSED_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_take && !req_write_i) |=> (!rsp_valid_o || rsp_data_o == '1)); // R7
  AST_FWD_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> busy_o); // R8
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> !fwd_valid_o); // R8
  AST_TIMEOUT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_evt_o |-> (rsp_valid_o && rsp_data_o == '1 && !busy_o)); // R9
  AST_IDLE_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> !rsp_valid_o); // R10
endmodule

bind cfg_win_decoder cfg_win_decoder_chk #(
  .INFO_W(INFO_W), .LIM_LSB(LIM_LSB), .LIM_W(LIM_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_write_i   (req_write_i),
  .req_offset_i  (req_offset_i),
  .root_bus_i    (root_bus_i),
  .prim_bus_i    (prim_bus_i),
  .link_up_i     (link_up_i),
  .bridge_info_i (bridge_info_i),
  .busy_o        (busy_o),
  .fwd_valid_o   (fwd_valid_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_data_o    (rsp_data_o),
  .timeout_evt_o (timeout_evt_o)
);

// File: tb/cfg_win_decoder_tb.sv
module cfg_win_decoder_tb;
  localparam int LIM = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [27:0] req_offset_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [7:0]  root_bus_i = '0, prim_bus_i = '0;
  logic        link_up_i = 1'b0;
  logic [31:0] bridge_info_i = '0;
  logic        cpl_valid_i = 1'b0;
  logic [31:0] cpl_data_i = '0;
  logic        busy_o, fwd_valid_o, fwd_write_o, rsp_valid_o, timeout_evt_o;
  logic [7:0]  fwd_bus_o, bus_max_o;
  logic [4:0]  fwd_dev_o;
  logic [2:0]  fwd_fn_o;
  logic [11:0] fwd_reg_o;
  logic [31:0] fwd_wdata_o, rsp_data_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cfg_win_decoder #(.TIMEOUT_CYC(LIM)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic bit exp_ok(int bus, int dev, int fn, int root, int prim, bit link, int lim);
    bit nz = (dev != 0) || (fn != 0);
    if (bus > lim) return 0;
    if (bus != root && !link) return 0;
    if (bus == root && nz) return 0;
    if (prim == root && nz) return 0;
    return 1;
  endfunction

  // cpl_at: 1..LIM completes on that cycle, anything else lets it time out
  task automatic access(input string tag, input int bus, input int dev, input int fn,
                        input int rg, input bit wr, input logic [31:0] wd,
                        input int root, input int prim, input bit link, input int lim,
                        input int cpl_at, input logic [31:0] cd);
    bit ok = exp_ok(bus, dev, fn, root, prim, link, lim);
    @(negedge clk_i);
    req_valid_i   = 1'b1;
    req_write_i   = wr;
    req_offset_i  = {bus[7:0], dev[4:0], fn[2:0], rg[11:0]};
    req_wdata_i   = wd;
    root_bus_i    = root[7:0];
    prim_bus_i    = prim[7:0];
    link_up_i     = link;
    bridge_info_i = $urandom;
    bridge_info_i[18:16] = lim[2:0];
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " R2 fwd"}, 32'(fwd_valid_o), 32'(ok));
    chk({tag, " R2 rsp"}, 32'(rsp_valid_o), 32'(!ok));
    if (!ok) begin
      chk({tag, " R7 data"}, rsp_data_o, wr ? 32'h0 : 32'hFFFF_FFFF);
      chk({tag, " R7 idle"}, 32'(busy_o), 32'd0);
    end else begin
      chk({tag, " R1 fields"}, {fwd_bus_o, fwd_dev_o, fwd_fn_o, fwd_reg_o, 3'b0, fwd_write_o},
          {bus[7:0], dev[4:0], fn[2:0], rg[11:0], 3'b0, wr});
      if (wr) chk({tag, " R1 wdata"}, fwd_wdata_o, wd);
      chk({tag, " R8 busy"}, 32'(busy_o), 32'd1);
      for (int j = 1; j <= LIM; j++) begin
        if (j == cpl_at) begin cpl_valid_i = 1'b1; cpl_data_i = cd; end
        @(negedge clk_i);
        cpl_valid_i = 1'b0;
        if (j == cpl_at) begin
          chk({tag, " R8 cpl"}, {rsp_data_o}, cd);
          chk({tag, " R8 flags"}, {29'd0, rsp_valid_o, timeout_evt_o, busy_o}, 32'b100);
          break;
        end else if (j == LIM) begin
          chk({tag, " R9 timeout"}, {29'd0, rsp_valid_o, timeout_evt_o, busy_o}, 32'b110);
          chk({tag, " R9 data"}, rsp_data_o, 32'hFFFF_FFFF);
        end else if (rsp_valid_o || timeout_evt_o) begin
          chk({tag, " R9 early"}, {30'd0, rsp_valid_o, timeout_evt_o}, 32'd0);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("R11 reset", {28'd0, busy_o, fwd_valid_o, rsp_valid_o, timeout_evt_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 after release", {28'd0, busy_o, fwd_valid_o, rsp_valid_o, timeout_evt_o}, 32'd0);

    bridge_info_i = 32'hFFF8_FFFF;   // field = 0 (bits 18:16 clear)
    #1 chk("R6 bus_max 0", 32'(bus_max_o), 32'd0);
    bridge_info_i = 32'h0005_0000;
    #1 chk("R6 bus_max 5", 32'(bus_max_o), 32'd5);

    // directed corners
    access("root dev0 read",     0, 0, 0, 12'h010, 0, 0,            0, 0, 1, 7, 3,   32'hA5A5_0001);
    access("root dev0 link dn",  1, 0, 0, 12'h004, 1, 32'h1234_5678, 1, 0, 0, 7, 1,  32'h0);
    access("R4 root fn1 read",   0, 0, 1, 12'h000, 0, 0,            0, 9, 1, 7, 1,   0);
    access("R4 root dev2 write", 0, 2, 0, 12'h000, 1, 32'hDEAD,     0, 9, 1, 7, 1,   0);
    access("R5 attached dev1",   1, 1, 0, 12'h008, 0, 0,            0, 0, 1, 7, 1,   0);
    access("R5 attached fn3 wr", 1, 0, 3, 12'h008, 1, 32'h55,       0, 0, 1, 7, 1,   0);
    access("R5 deeper dev1 ok",  2, 1, 2, 12'hFFC, 0, 0,            0, 1, 1, 7, 2,   32'hC0DE_0002);
    access("R3 link down",       2, 0, 0, 12'h000, 0, 0,            0, 1, 0, 7, 1,   0);
    access("R3 link down wr",    3, 0, 0, 12'h000, 1, 32'h77,       0, 1, 0, 7, 1,   0);
    access("R6 above limit",     4, 0, 0, 12'h000, 0, 0,            0, 1, 1, 3, 1,   0);
    access("R6 at limit",        3, 0, 0, 12'h100, 0, 0,            0, 1, 1, 3, 1,   32'h0000_0003);
    access("R9 tie last cycle",  1, 0, 0, 12'h040, 0, 0,            0, 0, 1, 7, LIM, 32'hBEEF_0010);
    access("R9 timeout",         1, 0, 0, 12'h044, 0, 0,            0, 0, 1, 7, 0,   0);
    access("R9 timeout write",   1, 0, 0, 12'h048, 1, 32'h99,       0, 0, 1, 7, 0,   0);

    // R10: completion while idle
    @(negedge clk_i);
    cpl_valid_i = 1'b1; cpl_data_i = 32'h1111_2222;
    @(negedge clk_i);
    cpl_valid_i = 1'b0;
    chk("R10 idle cpl", {30'd0, rsp_valid_o, busy_o}, 32'd0);

    // R8: strobe while busy is ignored
    access("R8 setup", 0, 0, 0, 12'h000, 0, 0, 0, 0, 1, 7, 2, 32'h2);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_offset_i = '0; root_bus_i = '0; link_up_i = 1'b1;
    bridge_info_i = 32'h0007_0000;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R8 fwd pulse", 32'(fwd_valid_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b1;          // sampled while busy
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R8 ignored strobe", {29'd0, fwd_valid_o, rsp_valid_o, busy_o}, 32'b001);
    cpl_valid_i = 1'b1; cpl_data_i = 32'h0BAD_F00D;
    @(negedge clk_i);
    cpl_valid_i = 1'b0;
    chk("R8 cpl after ignored", rsp_data_o, 32'h0BAD_F00D);
    chk("R8 busy cleared", {30'd0, rsp_valid_o, busy_o}, 32'b10);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int root = $urandom_range(0, 2);
      int bus  = $urandom_range(0, 8);
      int prim = ($urandom_range(0, 1) == 1) ? root : $urandom_range(0, 8);
      int dev  = ($urandom_range(0, 1) == 1) ? 0 : $urandom_range(0, 31);
      int fn   = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 0;
      bit link = $urandom_range(0, 3) != 0;
      int lim  = $urandom_range(2, 7);
      int cat  = $urandom_range(1, LIM + 2);
      access("R2 random", bus, dev, fn, $urandom_range(0, 4095), 1'($urandom),
             $urandom, root, prim, link, lim, cat, $urandom);
    end

    done = 1;
    report();
  end
endmodule